// File: doc/BRIEF.md
# Fuse-Initialised Power-of-Two Clock Prescaler

This block divides the system clock by a power of two and produces a one-cycle clock enable, `div_tick`, once per divided period. A three-bit select register chooses the exponent, so the divisor runs from 1 up to 128. A static strap input, `fuse_prog`, stands in for a non-volatile fuse and decides what the select register holds when reset ends. With the strap programmed (the shipped default) the select starts at 3, which means divide-by-8. With the strap unprogrammed the select starts at 0, which means no division.

After reset, software may write any select value through a single-cycle write port, whatever the strap says. The written value can be read back on the next cycle. The divider is a chain of divide-by-2 toggle stages followed by a tap multiplexer. A newly written select is held as pending and only becomes the applied select at the end of the divided period in progress, so no shortened period is ever produced.

A two-state controller tracks this. In `ST_RUN` the applied select equals the written select. A write that differs from the applied value takes the controller from `ST_RUN` to `ST_PEND`. At the next period boundary the pending value is applied and the controller goes from `ST_PEND` back to `ST_RUN`. It stays in `ST_PEND` if a different value was written in that same cycle. A write that restores the applied value also returns the controller from `ST_PEND` to `ST_RUN`.

Top module: `sysclk_prescaler`

## Requirements
- R1: With `fuse_prog` = 1 during reset, `sel_q` reads 3 after reset. `div_tick` is first high in the eighth cycle after release, counting the release cycle as the first.
- R2: With `fuse_prog` = 0 during reset, `sel_q` reads 0 after reset and `div_tick` is high in every cycle.
- R3: When `wr_en` is high at a clock edge, `sel_q` equals `wr_sel` from the next cycle on. This holds for every value 0 to 7, whatever the strap setting.
- R4: After reset, `fuse_prog` has no effect: changing it leaves `sel_q` and the `div_tick` period unchanged.
- R5: With applied select s, `div_tick` is high for one cycle in every 2^s cycles, for each s from 0 to 7.
- R6: A write takes effect only at a period boundary. The period in progress when the write lands completes at its old length.
- R7: Each period after a boundary starts counting from zero, so the first period at a new select is the full 2^s cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_prog | input | 1 | Strap: 1 = programmed (start at divide-by-8), 0 = unprogrammed (start at divide-by-1) |
| wr_en | input | 1 | Write strobe for the select register |
| wr_sel | input | 3 | Select value to write; divisor is 2^value |
| sel_q | output | 3 | Readback of the select register |
| div_tick | output | 1 | One-cycle enable at the end of each divided period |

## Verification
The assertions check several rules on every cycle. A write lands in the readback register on the next cycle. The register holds its value without a write, so the strap cannot reach it. The applied select changes only in a boundary cycle. The divider chain is empty after every boundary. `ST_RUN` always means the applied and written selects agree. Only the bench's scenarios can show the end-to-end behaviour: the actual period length for each of the eight selects, the start-up period under each strap setting, and that a write made just after a boundary still lets the old-length period finish.

// File: rtl/sysclk_prescaler_pkg.sv
package sysclk_prescaler_pkg;

    // Controller state: applied select matches written select, or a change waits.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } presc_state_e;

endpackage

// File: rtl/presc_toggle_chain.sv
// Cascade of divide-by-2 toggle stages; stage i flips when every stage below it is one.
module presc_toggle_chain #(
    parameter int STAGES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    output logic [STAGES-1:0] stage_q
);

    logic [STAGES:0] carry;

    assign carry[0] = 1'b1;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            assign carry[i+1] = carry[i] & stage_q[i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= 1'b0;
                end else if (clear) begin
                    stage_q[i] <= 1'b0;
                end else if (carry[i]) begin
                    stage_q[i] <= ~stage_q[i];
                end
            end
        end
    endgenerate

    // Each new period starts with an empty chain.
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (stage_q == '0));

endmodule

// File: rtl/presc_tap_mux.sv
// Picks the terminal-count tap of the toggle chain for the applied select.
module presc_tap_mux #(
    parameter int SEL_W  = 3,
    parameter int STAGES = 7
) (
    input  logic [STAGES-1:0] stage_q,
    input  logic [SEL_W-1:0]  act_sel,
    output logic              tick
);

    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] full;

    assign full[0] = 1'b1;

    generate
        for (genvar k = 1; k < TAPS; k++) begin : g_tap
            assign full[k] = full[k-1] & stage_q[k-1];
        end
    endgenerate

    always_comb begin
        tick = full[act_sel];
    end

endmodule

// File: rtl/presc_sel_ctrl.sv
// Select register, applied select and the pending-change controller.
module presc_sel_ctrl
    import sysclk_prescaler_pkg::*;
#(
    parameter int              SEL_W    = 3,
    parameter logic [SEL_W-1:0] FUSE_SEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_prog,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             tick,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] act_sel
);

    presc_state_e    state_q;
    presc_state_e    state_d;
    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] act_d;

    // State register together with the select registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= fuse_prog ? FUSE_SEL : '0;
            act_sel <= fuse_prog ? FUSE_SEL : '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            act_sel <= act_d;
        end
    end

    // Next-value logic.
    always_comb begin
        sel_d   = wr_en ? wr_sel : sel_q;
        act_d   = act_sel;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                // Applied select already matches; only a differing write opens a change.
                state_d = (sel_d != act_sel) ? ST_PEND : ST_RUN;
            end
            ST_PEND: begin
                if (tick) begin
                    act_d = sel_q;
                end
                state_d = (sel_d != act_d) ? ST_PEND : ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_q == $past(wr_sel)));

    assert_sel_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));

    assert_apply_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(act_sel));

    assert_run_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (act_sel == sel_q));

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int               SEL_W    = 3,
    parameter logic [SEL_W-1:0] FUSE_SEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_prog,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] sel_q,
    output logic             div_tick
);

    localparam int STAGES = (1 << SEL_W) - 1;

    logic [SEL_W-1:0]  act_sel;
    logic [STAGES-1:0] stage_q;
    logic              tick;

    presc_sel_ctrl #(
        .SEL_W   (SEL_W),
        .FUSE_SEL(FUSE_SEL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fuse_prog(fuse_prog),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .tick     (tick),
        .sel_q    (sel_q),
        .act_sel  (act_sel)
    );

    presc_toggle_chain #(
        .STAGES(STAGES)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tick),
        .stage_q(stage_q)
    );

    presc_tap_mux #(
        .SEL_W (SEL_W),
        .STAGES(STAGES)
    ) u_mux (
        .stage_q(stage_q),
        .act_sel(act_sel),
        .tick   (tick)
    );

    assign div_tick = tick;

endmodule

// File: tb/test_sysclk_prescaler.sv
module test_sysclk_prescaler;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_prog = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [2:0] sel_q;
    logic       div_tick;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference state.
    int m_sel = 3;
    int m_act = 3;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysclk_prescaler i_sysclk_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .fuse_prog(fuse_prog),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .sel_q    (sel_q),
        .div_tick (div_tick)
    );

    function automatic bit exp_tick();
        return m_cnt == ((1 << m_act) - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = fuse_prog ? 3 : 0;
            m_act = m_sel;
            m_cnt = 0;
        end else begin
            if (exp_tick()) begin
                m_cnt = 0;
                m_act = m_sel;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) m_sel = int'(wr_sel);
        end
    end

    // Every-cycle comparison against the reference (R3, R5, R6, R7).
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (div_tick !== exp_tick() || int'(sel_q) != m_sel) begin
                n_bad++;
                $display("FAIL R5/R3 model: tick=%0b sel=%0d expected tick=%0b sel=%0d",
                         div_tick, sel_q, exp_tick(), m_sel);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic fuse);
        @(posedge clk); #1;
        rst_n = 1'b0;
        fuse_prog = fuse;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic write_sel(input int v);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_sel = 3'(v);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Cycles from one tick to the next, sampled at negedges.
    task automatic period(output int n);
        do @(negedge clk); while (!div_tick);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_tick);
    endtask

    initial begin
        int p;
        int c;
        // R1: programmed strap.
        do_reset(1'b1);
        @(negedge clk);
        check("R1 reset select", int'(sel_q), 3);
        c = 1;
        while (!div_tick && c < 50) begin
            @(negedge clk);
            c++;
        end
        check("R1 first tick cycle", c, 8);
        period(p);
        check("R1 start period", p, 8);

        // R4: strap ignored after reset.
        @(posedge clk); #1 fuse_prog = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R4 select after strap change", int'(sel_q), 3);
        period(p);
        check("R4 period after strap change", p, 8);

        // R3 and R5: every select value.
        for (int s = 0; s < 8; s++) begin
            write_sel(s);
            @(negedge clk);
            check("R3 readback", int'(sel_q), s);
            repeat (300) @(posedge clk);
            period(p);
            check($sformatf("R5 period sel %0d", s), p, 1 << s);
        end

        // R6 / R7: write just after a boundary at select 2.
        write_sel(2);
        repeat (300) @(posedge clk);
        do @(negedge clk); while (!div_tick);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_sel = 3'd5;
        @(negedge clk);
        c = 1;
        @(posedge clk); #1 wr_en = 1'b0;
        while (!div_tick) begin
            @(negedge clk);
            c++;
        end
        check("R6 old period completes", c, 4);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!div_tick);
        check("R7 first new period", c, 32);

        // R2: unprogrammed strap.
        do_reset(1'b0);
        @(negedge clk);
        check("R2 reset select", int'(sel_q), 0);
        check("R2 tick at release", int'(div_tick), 1);
        @(negedge clk);
        check("R2 tick next cycle", int'(div_tick), 1);

        // R3: write any value with strap unprogrammed.
        write_sel(7);
        @(negedge clk);
        check("R3 write with strap off", int'(sel_q), 7);
        period(p);
        check("R5 period sel 7 strap off", p, 128);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule